// File: doc/BRIEF.md
# Paged Program Counter with Two-Entry Return Stack

This unit produces the fetch address for a small core with 12-bit instruction words. Each cycle the decoder raises at most one control strobe (step, jump, subroutine entry, computed low-byte write, or return with a literal), and the unit computes the next address. Address bits above bit 7 come from fixed rules, and a page bit from the status logic supplies the top bit. The result is always confined to the implemented program memory, which is 512 or 1024 words.

Subroutine linkage uses a two-entry return stack. An entry pushes the incremented address and a return pops it. A return also sends its 8-bit literal to the working register as a one-cycle load strobe. The stack has no reset. Entering a subroutine or writing the low byte always clears bit 8, so those targets can only fall in the lower half of a 512-word page. When the stack is popped, its deeper entry is copied upward and also stays where it is, so returns past two levels keep landing on the same address.

Top module: `pcu_top`

## Requirements
- R1: While reset is active and after it is released, `pc` equals MEM_WORDS-1 and `wreg_load` is 0, until the first accepted strobe.
- R2: `step_en` advances `pc` by one per cycle, and the address after MEM_WORDS-1 is 0.
- R3: `jump_en` loads `pc[8:0]` from `jump_addr`. With 1024 words, `pc[9]` is `page_sel`.
- R4: `enter_en` loads `pc[7:0]` from `enter_addr`, forces `pc[8]` to 0 and, with 1024 words, sets `pc[9]` from `page_sel`.
- R5: On `enter_en`, `stack_next` takes the old `stack_top`, and `stack_top` takes the old `pc`+1 wrapped to the memory size.
- R6: `lowwr_en` forms the address the same way as R4 from `lowwr_data` and leaves both stack entries unchanged.
- R7: On `leave_en`, `pc` takes `stack_top`, `stack_top` takes `stack_next`, and `stack_next` keeps its value. In the next cycle `wreg_load` is 1 and `wreg_value` equals `leave_lit`.
- R8: After more than two returns in a row, every further return loads `pc` with the value `stack_next` held.
- R9: Asserting reset leaves `stack_top` and `stack_next` unchanged.
- R10: When strobes coincide, priority is leave, then enter, then jump, then low-byte write, then step. With no strobe, `pc` and both stack entries hold.
- R11: `wreg_load` is 1 only in the cycle after an accepted `leave_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_en | input | 1 | Advance to the next address |
| jump_en | input | 1 | Jump with a 9-bit target |
| jump_addr | input | 9 | Jump target bits 8:0 |
| enter_en | input | 1 | Subroutine entry, pushes return address |
| enter_addr | input | 8 | Entry target bits 7:0 |
| lowwr_en | input | 1 | Computed write of the low address byte |
| lowwr_data | input | 8 | Low byte value |
| leave_en | input | 1 | Return, pops stack and loads literal |
| leave_lit | input | 8 | Literal for the working register |
| page_sel | input | 1 | Page bit from status, drives address bit 9 |
| pc | output | ADDR_W | Current program address |
| stack_top | output | ADDR_W | Return stack level 1 |
| stack_next | output | ADDR_W | Return stack level 2 |
| wreg_load | output | 1 | Working-register load strobe |
| wreg_value | output | 8 | Value for the working register |

## Verification
A faulty stack entry stays hidden until a return uses it. The fault then shows on `pc` one cycle after `leave_en`, and once more after two or more further returns, because the deeper entry is duplicated. For that reason the bench compares both stack ports after every cycle and does not rely on returns to reveal a fault. A wrong bit 8 or page bit, or a missing wrap, shows on `pc` in the cycle after the strobe that formed the address. Random strobe mixes include coincident strobes, so a wrong priority order appears as a wrong `pc` or stack value after one cycle.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  localparam int PAGE_BIT = 9;
  localparam int FULL_W   = 10;
  localparam int JUMP_W   = 9;
  localparam int BYTE_W   = 8;

  typedef enum logic [2:0] {
    PC_HOLD  = 3'd0,
    PC_STEP  = 3'd1,
    PC_LOWWR = 3'd2,
    PC_JUMP  = 3'd3,
    PC_ENTER = 3'd4,
    PC_LEAVE = 3'd5
  } pc_op_e;

endpackage

// File: rtl/pcu_rst_sync.sv
module pcu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;

endmodule

// File: rtl/pcu_op_arbiter.sv
module pcu_op_arbiter
  import pcu_pkg::*;
(
  input  logic   step_en,
  input  logic   jump_en,
  input  logic   enter_en,
  input  logic   lowwr_en,
  input  logic   leave_en,
  output pc_op_e op
);

  always_comb begin
    if (leave_en)      op = PC_LEAVE;
    else if (enter_en) op = PC_ENTER;
    else if (jump_en)  op = PC_JUMP;
    else if (lowwr_en) op = PC_LOWWR;
    else if (step_en)  op = PC_STEP;
    else               op = PC_HOLD;
  end

endmodule

// File: rtl/pcu_next_pc.sv
module pcu_next_pc
  import pcu_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  pc_op_e              op,
  input  logic [ADDR_W-1:0]   pc_cur,
  input  logic [ADDR_W-1:0]   ret_addr,
  input  logic                page_sel,
  input  logic [JUMP_W-1:0]   jump_addr,
  input  logic [BYTE_W-1:0]   enter_addr,
  input  logic [BYTE_W-1:0]   lowwr_data,
  output logic [ADDR_W-1:0]   pc_nxt,
  output logic [ADDR_W-1:0]   pc_inc
);

  logic [ADDR_W-1:0] jump_tgt;
  logic [ADDR_W-1:0] enter_tgt;
  logic [ADDR_W-1:0] lowwr_tgt;

  generate
    if (ADDR_W > PAGE_BIT) begin : g_paged
      assign jump_tgt  = {page_sel, jump_addr};
      assign enter_tgt = {page_sel, 1'b0, enter_addr};
      assign lowwr_tgt = {page_sel, 1'b0, lowwr_data};
    end else begin : g_flat
      assign jump_tgt  = jump_addr[ADDR_W-1:0];
      assign enter_tgt = {1'b0, enter_addr};
      assign lowwr_tgt = {1'b0, lowwr_data};
    end
  endgenerate

  assign pc_inc = pc_cur + {{(ADDR_W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (op)
      PC_STEP:  pc_nxt = pc_inc;
      PC_LOWWR: pc_nxt = lowwr_tgt;
      PC_JUMP:  pc_nxt = jump_tgt;
      PC_ENTER: pc_nxt = enter_tgt;
      PC_LEAVE: pc_nxt = ret_addr;
      default:  pc_nxt = pc_cur;
    endcase
  end

endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_val,
  output logic [ADDR_W-1:0] lvl1,
  output logic [ADDR_W-1:0] lvl2
);

  logic [ADDR_W-1:0] lvl1_q, lvl1_d;
  logic [ADDR_W-1:0] lvl2_q, lvl2_d;
  logic              stk_en;

  assign stk_en = push | pop;

  always_comb begin
    lvl1_d = lvl1_q;
    lvl2_d = lvl2_q;
    if (pop) begin
      lvl1_d = lvl2_q;
    end else if (push) begin
      lvl2_d = lvl1_q;
      lvl1_d = push_val;
    end
  end

  always_ff @(posedge clk) begin
    if (stk_en) begin
      lvl1_q <= lvl1_d;
      lvl2_q <= lvl2_d;
    end
  end

  assign lvl1 = lvl1_q;
  assign lvl2 = lvl2_q;

endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int MEM_WORDS = 1024,
  localparam int ADDR_W   = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              jump_en,
  input  logic [8:0]        jump_addr,
  input  logic              enter_en,
  input  logic [7:0]        enter_addr,
  input  logic              lowwr_en,
  input  logic [7:0]        lowwr_data,
  input  logic              leave_en,
  input  logic [7:0]        leave_lit,
  input  logic              page_sel,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] stack_top,
  output logic [ADDR_W-1:0] stack_next,
  output logic              wreg_load,
  output logic [7:0]        wreg_value
);

  localparam logic [ADDR_W-1:0] RESET_PC = ADDR_W'(MEM_WORDS - 1);

  logic              rst_int_n;
  pc_op_e            op;
  logic [ADDR_W-1:0] pc_q, pc_d, pc_inc;
  logic              pc_en;
  logic              push, pop;
  logic              wl_q, wl_d;
  logic [7:0]        wv_q, wv_d;

  pcu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  pcu_op_arbiter u_arb (
    .step_en  (step_en),
    .jump_en  (jump_en),
    .enter_en (enter_en),
    .lowwr_en (lowwr_en),
    .leave_en (leave_en),
    .op       (op)
  );

  pcu_next_pc #(.ADDR_W(ADDR_W)) u_next (
    .op         (op),
    .pc_cur     (pc_q),
    .ret_addr   (stack_top),
    .page_sel   (page_sel),
    .jump_addr  (jump_addr),
    .enter_addr (enter_addr),
    .lowwr_data (lowwr_data),
    .pc_nxt     (pc_d),
    .pc_inc     (pc_inc)
  );

  assign push = rst_int_n && (op == PC_ENTER);
  assign pop  = rst_int_n && (op == PC_LEAVE);

  pcu_ret_stack #(.ADDR_W(ADDR_W)) u_stack (
    .clk      (clk),
    .push     (push),
    .pop      (pop),
    .push_val (pc_inc),
    .lvl1     (stack_top),
    .lvl2     (stack_next)
  );

  assign pc_en = (op != PC_HOLD);
  assign wl_d  = (op == PC_LEAVE);
  assign wv_d  = leave_lit;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q <= RESET_PC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      wl_q <= 1'b0;
      wv_q <= 8'h00;
    end else begin
      wl_q <= wl_d;
      if (wl_d) begin
        wv_q <= wv_d;
      end
    end
  end

  assign pc         = pc_q;
  assign wreg_load  = wl_q;
  assign wreg_value = wv_q;

  assert_jump_target_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (jump_en && !leave_en && !enter_en) |=> (pc[8:0] == $past(jump_addr)));

  assert_enter_half_page_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (enter_en && !leave_en) |=> (pc[7:0] == $past(enter_addr)) && !pc[8]);

  assert_enter_push_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (enter_en && !leave_en) |=>
      (stack_top == $past(pc) + ADDR_W'(1)) && (stack_next == $past(stack_top)));

  assert_lowwr_keeps_stack_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lowwr_en && !leave_en && !enter_en && !jump_en) |=>
      $stable(stack_top) && $stable(stack_next) && !pc[8]);

  assert_leave_pop_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    leave_en |=> (pc == $past(stack_top)) && (stack_top == $past(stack_next))
                 && $stable(stack_next));

  assert_leave_wreg_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    leave_en |=> wreg_load && (wreg_value == $past(leave_lit)));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(step_en || jump_en || enter_en || lowwr_en || leave_en) |=>
      $stable(pc) && $stable(stack_top) && $stable(stack_next));

  assert_wreg_quiet_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !leave_en |=> !wreg_load);

endmodule

// File: tb/pcu_top_bench.sv
`timescale 1ns/1ps
module pcu_top_bench;

  localparam int MEM_WORDS = 1024;
  localparam int AW        = 10;
  localparam int MAX_CYC   = 200000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          step_en, jump_en, enter_en, lowwr_en, leave_en, page_sel;
  logic [8:0]    jump_addr;
  logic [7:0]    enter_addr, lowwr_data, leave_lit;
  logic [AW-1:0] pc, stack_top, stack_next;
  logic          wreg_load;
  logic [7:0]    wreg_value;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [AW-1:0] e_pc, e_s1, e_s2;
  logic          e_wl;
  logic [7:0]    e_wv;
  bit            s1_ok, s2_ok;
  int            leave_run;

  always #2 clk = ~clk;

  pcu_top #(.MEM_WORDS(MEM_WORDS)) u_pcu_top (
    .clk(clk), .rst_n(rst_n),
    .step_en(step_en), .jump_en(jump_en), .jump_addr(jump_addr),
    .enter_en(enter_en), .enter_addr(enter_addr),
    .lowwr_en(lowwr_en), .lowwr_data(lowwr_data),
    .leave_en(leave_en), .leave_lit(leave_lit), .page_sel(page_sel),
    .pc(pc), .stack_top(stack_top), .stack_next(stack_next),
    .wreg_load(wreg_load), .wreg_value(wreg_value)
  );

  function automatic logic [AW-1:0] form_jump(logic pg, logic [8:0] a);
    return {pg, a};
  endfunction

  function automatic logic [AW-1:0] form_low(logic pg, logic [7:0] b);
    return {pg, 1'b0, b};
  endfunction

  function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] a);
    return (a == AW'(MEM_WORDS - 1)) ? '0 : a + 1'b1;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    step_en = 0; jump_en = 0; enter_en = 0; lowwr_en = 0; leave_en = 0;
    page_sel = 0; jump_addr = '0; enter_addr = '0; lowwr_data = '0; leave_lit = '0;
  endtask

  task automatic compare_all(string req);
    chk(req, "pc", pc, e_pc);
    chk(req, "wreg_load", wreg_load, e_wl);
    if (e_wl) chk(req, "wreg_value", wreg_value, e_wv);
    if (s1_ok) chk(req, "stack_top", stack_top, e_s1);
    if (s2_ok) chk(req, "stack_next", stack_next, e_s2);
  endtask

  // Applies inputs already set at a falling edge, updates the model, checks.
  task automatic cycle_and_check();
    string req;
    int n;
    n = int'(step_en) + int'(jump_en) + int'(enter_en) + int'(lowwr_en) + int'(leave_en);
    e_wl = 0;
    if (leave_en) begin
      leave_run++;
      req = (leave_run > 2) ? "R8" : "R7";
      e_pc = e_s1; e_s1 = e_s2; s1_ok = s2_ok;
      e_wl = 1; e_wv = leave_lit;
    end else begin
      leave_run = 0;
      if (enter_en) begin
        req = "R5";
        e_s2 = e_s1; s2_ok = s1_ok;
        e_s1 = wrap_inc(e_pc); s1_ok = 1;
        e_pc = form_low(page_sel, enter_addr);
      end else if (jump_en) begin
        req = "R3"; e_pc = form_jump(page_sel, jump_addr);
      end else if (lowwr_en) begin
        req = "R6"; e_pc = form_low(page_sel, lowwr_data);
      end else if (step_en) begin
        req = "R2"; e_pc = wrap_inc(e_pc);
      end else begin
        req = "R10";
      end
    end
    if (n > 1) req = "R10";
    @(posedge clk);
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic do_reset(string req);
    rst_n = 0;
    idle_inputs();
    @(negedge clk);
    @(negedge clk);
    e_pc = AW'(MEM_WORDS - 1); e_wl = 0; leave_run = 0;
    compare_all(req);
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seed_dummy;
    logic [AW-1:0] keep1, keep2;
    seed_dummy = $urandom(32'd24681);
    s1_ok = 0; s2_ok = 0; e_wv = '0;
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    // R1: reset vector at the last location, no working-register strobe
    do_reset("R1");

    // R2: roll over from the last location to zero
    step_en = 1; cycle_and_check();
    chk("R2", "pc after wrap", pc, 0);
    step_en = 1; cycle_and_check();

    // R4/R5: two entries fill the stack; page bit feeds bit 9, bit 8 forced low
    idle_inputs(); enter_en = 1; enter_addr = 8'hAB; page_sel = 1; cycle_and_check();
    chk("R4", "entry target", pc, 10'h2AB);
    idle_inputs(); enter_en = 1; enter_addr = 8'hFF; page_sel = 0; cycle_and_check();
    chk("R5", "stack_top after entry", stack_top, 10'h2AC);

    // R3: jump with all field bits set on page 1
    idle_inputs(); jump_en = 1; jump_addr = 9'h1FF; page_sel = 1; cycle_and_check();
    chk("R3", "jump target", pc, 10'h3FF);

    // R6: computed low-byte write clears bit 8, stack untouched
    idle_inputs(); lowwr_en = 1; lowwr_data = 8'h5A; page_sel = 1; cycle_and_check();
    chk("R6", "low write target", pc, 10'h25A);

    // R2: entry from the last location pushes the wrapped address 0
    idle_inputs(); jump_en = 1; jump_addr = 9'h1FF; page_sel = 1; cycle_and_check();
    idle_inputs(); enter_en = 1; enter_addr = 8'h10; cycle_and_check();
    chk("R2", "wrapped return address", stack_top, 0);

    // R9: reset in the middle keeps both stack entries
    keep1 = e_s1; keep2 = e_s2;
    do_reset("R9");
    chk("R9", "stack_top kept", stack_top, keep1);
    chk("R9", "stack_next kept", stack_next, keep2);

    // R7/R8: four returns in a row, the last two repeat the deeper entry
    for (int k = 0; k < 4; k++) begin
      idle_inputs(); leave_en = 1; leave_lit = 8'(8'h30 + k); cycle_and_check();
    end
    chk("R8", "repeated deep return", pc, keep2);

    // R11: no strobe without a return
    idle_inputs(); cycle_and_check();
    chk("R11", "wreg_load idle", wreg_load, 0);

    // R10: all strobes at once, return wins; then entry beats jump
    idle_inputs(); enter_en = 1; enter_addr = 8'h44; cycle_and_check();
    idle_inputs(); leave_en = 1; enter_en = 1; jump_en = 1; lowwr_en = 1; step_en = 1;
    leave_lit = 8'hC3; jump_addr = 9'h0AA; cycle_and_check();
    chk("R10", "return has priority", wreg_value, 8'hC3);
    idle_inputs(); enter_en = 1; jump_en = 1; enter_addr = 8'h77; jump_addr = 9'h155;
    cycle_and_check();

    // Random mixes
    for (int i = 0; i < 3000; i++) begin
      idle_inputs();
      step_en    = ($urandom() % 100) < 45;
      jump_en    = ($urandom() % 100) < 15;
      enter_en   = ($urandom() % 100) < 15;
      lowwr_en   = ($urandom() % 100) < 12;
      leave_en   = ($urandom() % 100) < 15;
      page_sel   = $urandom() % 2;
      jump_addr  = 9'($urandom());
      enter_addr = 8'($urandom());
      lowwr_data = 8'($urandom());
      leave_lit  = 8'($urandom());
      cycle_and_check();
    end

    finish_run();
  end

endmodule